// File: doc/BRIEF.md
# Staged Integer Clock Divider Bank

This block turns one reference clock into as many as nine divided clocks. Each divided clock comes out as a one-cycle clock-enable strobe in the reference domain, together with a per-output enable flag. Each divider has its own setting, made of an enable flag and a ratio field that holds the ratio minus one. Software writes these settings through a simple single-cycle register port. The same port also holds the settings for the surrounding PLL: a multiplier field and two pre/post divider settings. These are passed straight through to output pins.

Divider settings go into a shadow copy first. Nothing reaches the running dividers until software writes a start command. The copy into the live dividers happens on one edge, for all dividers together. A busy flag then stays high for a fixed window while the outputs settle, and software polls that flag through a status register. An alignment mask picks which dividers restart their count from zero at the start command, so that their strobes land on common edges.

Top module: `clkdiv_bank`

## Requirements
- R1: After a synchronous reset, every strobe (`div_tick`), every enable flag (`div_en`), `busy`, `rdata` and all registers are zero.
- R2: A divider register (addresses 0 to NUM_DIV-1, index i for divider i) keeps bit 15 as the enable and bits [RATIO_W-1:0] as the ratio minus one. It reads back with all other bits zero.
- R3: A write to a divider register leaves `div_en` and `div_tick` unchanged until a start command is accepted.
- R4: Writing a word with bit 0 set to the command address (12) while idle loads every shadow setting into the live dividers on that edge. `busy` is 1 from the next cycle, and bit 0 of the status register (address 13) reads 1.
- R5: `busy` stays high for exactly 2^RATIO_W + 2 cycles (34 by default) and then clears. A start command written while busy is ignored and does not lengthen the window.
- R6: An enabled divider with ratio N>1 raises its strobe for one cycle out of every N. With ratio 1 the strobe is high on every cycle.
- R7: A divider whose live enable is 0 holds its strobe low and its `div_en` low. Writing 0 to its register and issuing a start command disables it.
- R8: Alignment mask bit i (address 14) restarts divider i at the start command. An aligned divider with ratio N gives its first strobe exactly N cycles after the accepting edge, so aligned dividers strobe together at common multiples.
- R9: The multiplier register (address 9) keeps an 8-bit field. The pre-divider (10) and post-divider (11) registers keep bit 15 plus the ratio bits. All three drive their output pins directly and read back.
- R10: A divider write made while busy lands in the shadow copy and reads back at once. The running divider keeps its old ratio after the window ends, until the next start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data appears one cycle later |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, held between reads |
| busy | output | 1 | Start-command window in progress |
| div_tick | output | NUM_DIV | Per-divider clock-enable strobe |
| div_en | output | NUM_DIV | Live per-divider enable |
| pll_mult | output | 8 | Multiplier minus one |
| pre_cfg | output | 16 | Pre-divider setting (bit 15 enable, low bits ratio minus one) |
| post_cfg | output | 16 | Post-divider setting, same layout |

## Verification
The bench watches the strobe phases from the exact accepting edge. A design that failed to reset aligned counters, or that applied settings one edge late, would shift the first strobe of a ratio-4 or ratio-2 divider away from cycles 4 and 2. It counts the busy window while a second start command is issued in the middle, so a window that restarts or ends early shows up as a count other than 34. Divider writes made during the window are read back and timed afterwards. A design that let them reach the live dividers early would show the new period before the next start command. Further checks cover the masking of unused register bits on readback and a divider that is disabled yet still strobes.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 16;
  localparam int ENA_BIT   = 15;
  localparam int MULT_W    = 8;
  localparam int A_MULT    = 9;
  localparam int A_PRE     = 10;
  localparam int A_POST    = 11;
  localparam int A_CMD     = 12;
  localparam int A_STAT    = 13;
  localparam int A_ALIGN   = 14;

  typedef enum logic [1:0] {CH_IDLE, CH_RUN} ch_state_e;
endpackage

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 9,
  parameter int RATIO_W = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic                              busy,
  output logic [DATA_W-1:0]                 rdata,
  output logic [NUM_DIV-1:0]                sh_en,
  output logic [NUM_DIV-1:0][RATIO_W-1:0]   sh_m1,
  output logic [NUM_DIV-1:0]                align_mask,
  output logic [MULT_W-1:0]                 mult_q,
  output logic [DATA_W-1:0]                 pre_q,
  output logic [DATA_W-1:0]                 post_q
);
  logic [DATA_W-1:0] rd_nxt;
  logic              unused_wbits;
  assign unused_wbits = ^wdata;

  function automatic logic [DATA_W-1:0] pack_div(input logic en, input logic [RATIO_W-1:0] m1);
    logic [DATA_W-1:0] w;
    w = '0;
    w[ENA_BIT] = en;
    w[RATIO_W-1:0] = m1;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_en      <= '0;
      sh_m1      <= '0;
      align_mask <= '0;
      mult_q     <= '0;
      pre_q      <= '0;
      post_q     <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_DIV; i++) begin
        if (addr == ADDR_W'(i)) begin
          sh_en[i] <= wdata[ENA_BIT];
          sh_m1[i] <= wdata[RATIO_W-1:0];
        end
      end
      if (addr == ADDR_W'(A_MULT))  mult_q     <= wdata[MULT_W-1:0];
      if (addr == ADDR_W'(A_PRE))   pre_q      <= pack_div(wdata[ENA_BIT], wdata[RATIO_W-1:0]);
      if (addr == ADDR_W'(A_POST))  post_q     <= pack_div(wdata[ENA_BIT], wdata[RATIO_W-1:0]);
      if (addr == ADDR_W'(A_ALIGN)) align_mask <= wdata[NUM_DIV-1:0];
    end
  end

  always_comb begin
    rd_nxt = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (addr == ADDR_W'(i)) rd_nxt = pack_div(sh_en[i], sh_m1[i]);
    end
    if (addr == ADDR_W'(A_MULT))  rd_nxt = DATA_W'(mult_q);
    if (addr == ADDR_W'(A_PRE))   rd_nxt = pre_q;
    if (addr == ADDR_W'(A_POST))  rd_nxt = post_q;
    if (addr == ADDR_W'(A_STAT))  rd_nxt = DATA_W'(busy);
    if (addr == ADDR_W'(A_ALIGN)) rd_nxt = DATA_W'(align_mask);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end
endmodule

// File: rtl/clkdiv_go_ctrl.sv
`timescale 1ns/1ps
module clkdiv_go_ctrl #(
  parameter int GO_CYCLES = 34
) (
  input  logic clk,
  input  logic rst,
  input  logic go_req,
  output logic apply,
  output logic busy
);
  localparam int TMR_W = $clog2(GO_CYCLES + 1);
  logic [TMR_W-1:0] tmr;

  assign apply = go_req && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      tmr  <= '0;
    end else if (apply) begin
      busy <= 1'b1;
      tmr  <= TMR_W'(GO_CYCLES - 1);
    end else if (busy) begin
      if (tmr == '0) busy <= 1'b0;
      else           tmr  <= tmr - 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_channel.sv
`timescale 1ns/1ps
module clkdiv_channel
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               apply,
  input  logic               align,
  input  logic               sh_en,
  input  logic [RATIO_W-1:0] sh_m1,
  output logic               tick,
  output logic               en
);
  logic [RATIO_W-1:0] m1;
  logic [RATIO_W-1:0] cnt;
  ch_state_e          st;

  assign en = (st == CH_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= CH_IDLE;
      m1   <= '0;
      cnt  <= '0;
      tick <= 1'b0;
    end else if (apply) begin
      st   <= sh_en ? CH_RUN : CH_IDLE;
      m1   <= sh_m1;
      tick <= 1'b0;
      if (align || !sh_en || cnt >= sh_m1) cnt <= '0;
      else                                 cnt <= cnt + 1'b1;
    end else if (st == CH_IDLE) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == m1);
      cnt  <= (cnt == m1) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 9,
  parameter int RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [3:0]         addr,
  input  logic [15:0]        wdata,
  output logic [15:0]        rdata,
  output logic               busy,
  output logic [NUM_DIV-1:0] div_tick,
  output logic [NUM_DIV-1:0] div_en,
  output logic [7:0]         pll_mult,
  output logic [15:0]        pre_cfg,
  output logic [15:0]        post_cfg
);
  localparam int GO_CYCLES = (1 << RATIO_W) + 2;

  logic [NUM_DIV-1:0]              sh_en;
  logic [NUM_DIV-1:0][RATIO_W-1:0] sh_m1;
  logic [NUM_DIV-1:0]              align_mask;
  logic                            go_req;
  logic                            apply;

  assign go_req = wr_en && (addr == ADDR_W'(A_CMD)) && wdata[0];

  clkdiv_regs #(.NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .busy(busy), .rdata(rdata), .sh_en(sh_en), .sh_m1(sh_m1),
    .align_mask(align_mask), .mult_q(pll_mult), .pre_q(pre_cfg), .post_q(post_cfg)
  );

  clkdiv_go_ctrl #(.GO_CYCLES(GO_CYCLES)) go_i (
    .clk(clk), .rst(rst), .go_req(go_req), .apply(apply), .busy(busy)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_ch
    clkdiv_channel #(.RATIO_W(RATIO_W)) ch_i (
      .clk(clk), .rst(rst), .apply(apply), .align(align_mask[g]),
      .sh_en(sh_en[g]), .sh_m1(sh_m1[g]), .tick(div_tick[g]), .en(div_en[g])
    );
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 9,
  parameter int RATIO_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [3:0]         addr,
  input logic [15:0]        wdata,
  input logic               busy,
  input logic [NUM_DIV-1:0] div_tick,
  input logic [NUM_DIV-1:0] div_en
);
  localparam int WIN = (1 << RATIO_W) + 2;
  logic [31:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1;
    else           bcnt <= '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!busy && div_tick == '0 && div_en == '0));

  assert_hold_until_go_R3: assert property (@(posedge clk) disable iff (rst)
    !$rose(busy) |-> $stable(div_en));

  assert_go_starts_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_CMD) && wdata[0] && !busy) |=> busy);

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> bcnt < WIN);

  assert_window_len_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(bcnt) == WIN - 1);

  assert_off_is_low_R7: assert property (@(posedge clk) disable iff (rst)
    (div_tick & ~div_en) == '0);
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NUM_DIV(NUM_DIV), .RATIO_W(RATIO_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .busy(busy), .div_tick(div_tick), .div_en(div_en)
);

// File: tb/clkdiv_bank_tb_top.sv
`timescale 1ns/1ps
module clkdiv_bank_tb_top;
  localparam int ND = 9;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          busy;
  logic [ND-1:0] div_tick, div_en;
  logic [7:0]    pll_mult;
  logic [15:0]   pre_cfg, post_cfg;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  clkdiv_bank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .div_tick(div_tick),
    .div_en(div_en), .pll_mult(pll_mult), .pre_cfg(pre_cfg), .post_cfg(post_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  task automatic period(input int idx, output int p);
    int g;
    g = 0;
    while (!div_tick[idx] && g < 100) begin @(negedge clk); g++; end
    p = 0;
    do begin @(negedge clk); p++; end while (!div_tick[idx] && p < 100);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 tick", div_tick, 0);
    chk("R1 en", div_en, 0);
    chk("R1 rdata", rdata, 0);
  endtask

  task automatic t_layout();
    logic [15:0] d;
    wr(4'd0, 16'h8003);
    rd(4'd0, d); chk("R2 div0 readback", d, 16'h8003);
    wr(4'd1, 16'hFFFF);
    rd(4'd1, d); chk("R2 masked bits", d, 16'h801F);
    repeat (10) @(negedge clk);
    chk("R3 en held", div_en, 0);
    chk("R3 tick held", div_tick, 0);
  endtask

  task automatic t_pllregs();
    logic [15:0] d;
    wr(4'd9, 16'h01FF);
    chk("R9 mult pin", pll_mult, 8'hFF);
    rd(4'd9, d); chk("R9 mult read", d, 16'h00FF);
    wr(4'd10, 16'h8004);
    chk("R9 pre pin", pre_cfg, 16'h8004);
    wr(4'd11, 16'h7FFF);
    rd(4'd11, d); chk("R9 post read", d, 16'h001F);
  endtask

  task automatic t_go_align();
    logic [15:0] d;
    int p;
    wr(4'd0, 16'h8003);
    wr(4'd1, 16'h8000);
    wr(4'd2, 16'h8001);
    wr(4'd14, 16'h0005);
    wr(4'd12, 16'h0001);
    chk("R4 busy set", busy, 1);
    chk("R4 en loaded", div_en[2:0], 3'b111);
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      chk("R8 aligned ratio4", div_tick[0], (k % 4) == 0);
      chk("R6 ratio1 pass", div_tick[1], 1);
      chk("R8 aligned ratio2", div_tick[2], (k % 2) == 0);
    end
    rd(4'd13, d); chk("R4 status busy", d, 16'h0001);
    wr(4'd0, 16'h8007);
    rd(4'd0, d); chk("R10 shadow read", d, 16'h8007);
    chk("R10 en kept", div_en[0], 1);
    wait_idle();
    rd(4'd13, d); chk("R5 status clear", d, 16'h0000);
    period(0, p); chk("R10 old ratio kept", p, 4);
    wr(4'd12, 16'h0001);
    wait_idle();
    period(0, p); chk("R6 new ratio 8", p, 8);
  endtask

  task automatic t_busy_len();
    int n;
    wr(4'd12, 16'h0001);
    n = 0;
    for (int k = 0; k < 200 && busy; k++) begin
      n++;
      if (k == 5) begin wr_en = 1'b1; addr = 4'd12; wdata = 16'h0001; end
      if (k == 6) wr_en = 1'b0;
      @(negedge clk);
    end
    chk("R5 window length", n, 34);
  endtask

  task automatic t_disable();
    int ones;
    wr(4'd0, 16'h0000);
    wr(4'd12, 16'h0001);
    wait_idle();
    chk("R7 en low", div_en[0], 0);
    ones = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (div_tick[0]) ones++;
    end
    chk("R7 tick low", ones, 0);
  endtask

  initial begin
    #(20 * 200000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_layout();
    t_pllregs();
    t_go_align();
    t_busy_len();
    t_disable();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule